// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port (Controller or Target)

This block exchanges one byte at a time, in both directions at once, over a four-wire synchronous serial link: a serial clock, a data line out of the controller, a data line back into it, and an active-low select. A small register interface lets a processor choose the role, the bit order, the clock polarity and phase, and the serial clock rate. It writes the byte to send and reads the byte received. A done flag and a collision flag report progress, and the done flag can also raise an interrupt request.

In controller role the block divides the system clock to make the serial clock. It pulls its select output low for exactly one byte. In target role it brings the external clock, data and select in through synchronisers. It reacts only while the select is low, and it drives its return data line only then. A write to the data register during a byte in flight is refused and flagged. The byte being shifted is not touched.

Top module: `spi_port`

## Requirements
- R1: In controller role the serial clock toggles every H system clocks. H is N/2, where N is the divider: rate field 0,1,2,3 gives N = 4,16,64,128, and the double-speed bit (status bit 0) halves N, giving 2,8,32,64. The first toggle comes H clocks after the clock edge that takes the data write.
- R2: In controller role a data write while idle drives `ss_n_out` low from the next clock. It holds it low for 16 serial-clock half periods, which is 8 clock cycles. After that `ss_n_out` goes high and `sck_out` rests at the polarity bit.
- R3: Control bit 4 (lsb_first) set sends and assembles bit 0 first. When clear, bit 7 goes first.
- R4: Control bit 3 is polarity and control bit 2 is phase. With phase 0, data is sampled on odd (leading) edges and changes on even edges. With phase 1, data changes on leading edges after the first and is sampled on trailing edges.
- R5: The byte received during a transfer appears at data address 2 when the byte completes.
- R6: At byte end, status bit 7 (done) is set. `irq` is high while done is set and control bit 6 (interrupt enable) is set.
- R7: A data write while a byte is in flight sets status bit 6 (collision) and does not change the byte being sent.
- R8: A status read (address 1) that sees a flag set, followed by a read or write of address 2, clears both flags. A data access without that prior status read leaves them set.
- R9: In target role (control bit 5 clear), with `ss_n_in` high, `miso_oe` is low and serial clock edges are ignored. With it low, the loaded byte is shifted out on `miso_out` and `mosi_in` is collected.
- R10: A rise of `ss_n_in` in the middle of a byte discards the partial byte without setting done. The next selected byte starts again from its first bit.
- R11: After reset all registers read 0, `ss_n_out` is high, `sck_out`, `irq` and `miso_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for the flag clear sequence) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Serial clock driven in controller role |
| mosi_out | output | 1 | Controller data out |
| ss_n_out | output | 1 | Controller select, active low |
| miso_in | input | 1 | Controller data in |
| sck_in | input | 1 | Serial clock received in target role |
| mosi_in | input | 1 | Target data in |
| ss_n_in | input | 1 | Target select, active low |
| miso_out | output | 1 | Target data out |
| miso_oe | output | 1 | Output enable for `miso_out` |

## Verification
Controller transfers are run in all four clock modes, at the fastest divider (2), a middle one and the slowest (128). Each transfer uses an asymmetric byte in each direction, so a swapped edge, a wrong divider or a reversed bit order shows up on a different clock or bit. One transfer has a collision write mid-byte and is compared against the same expected bit stream. The flag sequence is tried both with and without the preceding status read. Target transfers are run in two modes. One is preceded by a select that rises after two bits, followed by clock toggles with the select high, which shows whether the bit count restarts and idle edges are ignored.

// File: rtl/spi_port_pkg.sv
// Shared definitions for the serial port: register addresses, control
// layout and the divider exponent table. Assumes an 8-bit register bus.
package spi_port_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    // Control register, bit 6 down to bit 0.
    typedef struct packed {
        logic       irq_en;
        logic       master;
        logic       lsb_first;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    // log2 of the half period in system clocks.
    function automatic logic [2:0] half_exp(input logic [1:0] rate, input logic dbl);
        logic [2:0] e;
        case (rate)
            2'd0:    e = 3'd1;
            2'd1:    e = 3'd3;
            2'd2:    e = 3'd5;
            default: e = 3'd6;
        endcase
        return e - {2'b00, dbl};
    endfunction
endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchroniser for asynchronous inputs. Assumes the inputs are
// level signals slow compared with clk; reset loads RST_VAL into all stages.
module spi_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the sampled value one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n)      stg[g] <= RST_VAL;
                else if (g == 0) stg[g] <= d;
                else             stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_clkdiv.sv
// Serial clock prescaler: emits a one-cycle tick every H system clocks while
// run is high. restart aligns the count to the clock that accepts a byte.
module spi_clkdiv #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] rate,
    input  logic       dbl,
    output logic       tick
);
    import spi_port_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((32'd1 << half_exp(rate, dbl)) - 32'd1);

    // Count system clocks within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (restart || !run)        cnt <= '0;
        else if (cnt == limit)           cnt <= '0;
        else                             cnt <= cnt + CNT_W'(1);
    end

    assign tick = run && !restart && (cnt == limit);
endmodule

// File: rtl/spi_shift.sv
// Bit engine shared by both roles. Counts serial clock edges, picks the bit
// to send, stores sampled bits and flags the last edge of a byte. Assumes
// edges alternate leading/trailing starting from the idle level.
module spi_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sck_edge,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              odd_phase,
    output logic              active,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int EDGES = 2 * DATA_W;
    localparam int E_W   = $clog2(EDGES);
    localparam int B_W   = $clog2(DATA_W);

    logic [E_W-1:0]    ecnt;
    logic [B_W-1:0]    bpos;
    logic [B_W-1:0]    idx;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic              lead, do_sample, do_shift, last;

    assign lead      = !ecnt[0];
    assign do_sample = sck_edge && (cpha ? !lead : lead);
    assign do_shift  = sck_edge && (cpha ? (lead && ecnt != '0) : !lead);
    assign last      = sck_edge && (ecnt == E_W'(EDGES-1));
    assign idx       = lsb_first ? bpos : (B_W'(DATA_W-1) - bpos);

    // Merge the bit sampled on this edge into the received word.
    always_comb begin
        rx_word = rx_q;
        if (do_sample) rx_word[idx] = ser_in;
    end

    // Hold the byte to send; loaded only when the top accepts a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_q <= '0;
        else if (load) tx_q <= load_data;
    end

    // Advance edge and bit counters and capture received bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt <= '0;
            bpos <= '0;
            rx_q <= '0;
        end else if (clr) begin
            ecnt <= '0;
            bpos <= '0;
        end else begin
            rx_q <= rx_word;
            if (last)          ecnt <= '0;
            else if (sck_edge) ecnt <= ecnt + E_W'(1);
            if (last)          bpos <= '0;
            else if (do_shift) bpos <= bpos + B_W'(1);
        end
    end

    assign ser_out   = tx_q[idx];
    assign odd_phase = ecnt[0];
    assign active    = (ecnt != '0);
    assign byte_done = last && !clr;
endmodule

// File: rtl/spi_port.sv
// Register-controlled serial port, controller or target role. Holds the
// control, status and receive registers, chooses the edge source per role
// and drives the pins. Assumes target-side inputs are asynchronous.
module spi_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq,
    output logic        sck_out,
    output logic        mosi_out,
    output logic        ss_n_out,
    input  logic        miso_in,
    input  logic        sck_in,
    input  logic        mosi_in,
    input  logic        ss_n_in,
    output logic        miso_out,
    output logic        miso_oe
);
    import spi_port_pkg::*;

    ctrl_t             ctrl_q;
    logic              dbl_q, done_q, wcol_q, armed_q, busy_q, sck_prev;
    logic [DATA_W-1:0] rxbuf_q, rx_word;
    logic [2:0]        sync_q;
    logic              sck_s, mosi_s, ss_s;
    logic              wr_data, data_acc, xfer_live, accept, collide, clear_now;
    logic              m_tick, s_edge, sh_edge, sh_clr, ser_out, odd_phase, sh_active, byte_done;
    logic              is_master, cpol_sel;

    assign is_master = ctrl_q.master;
    assign cpol_sel  = ctrl_q.cpol;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sck_in, mosi_in, ss_n_in}), .q(sync_q)
    );
    assign {sck_s, mosi_s, ss_s} = sync_q;

    assign wr_data   = wr_en && (addr == A_DATA);
    assign data_acc  = (wr_en || rd_en) && (addr == A_DATA);
    assign xfer_live = is_master ? busy_q : sh_active;
    assign accept    = wr_data && !xfer_live;
    assign collide   = wr_data && xfer_live;
    assign clear_now = armed_q && data_acc;

    spi_clkdiv #(.CNT_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy_q && is_master), .restart(accept),
        .rate(ctrl_q.rate), .dbl(dbl_q), .tick(m_tick)
    );

    assign s_edge  = !is_master && !ss_s && (sck_s != sck_prev);
    assign sh_edge = is_master ? m_tick : s_edge;
    assign sh_clr  = !is_master && ss_s;

    spi_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(accept),
        .load_data(wdata[DATA_W-1:0]), .sck_edge(sh_edge), .cpha(ctrl_q.cpha),
        .lsb_first(ctrl_q.lsb_first), .ser_in(is_master ? miso_in : mosi_s),
        .ser_out(ser_out), .odd_phase(odd_phase), .active(sh_active),
        .byte_done(byte_done), .rx_word(rx_word)
    );

    // Keep the previous synchronised target clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // Software-written control and rate-doubling bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dbl_q  <= 1'b0;
        end else if (wr_en && addr == A_CTRL) begin
            ctrl_q <= ctrl_t'(wdata[6:0]);
        end else if (wr_en && addr == A_STAT) begin
            dbl_q  <= wdata[0];
        end
    end

    // Controller busy from accepted write until the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  busy_q <= 1'b0;
        else if (accept && is_master) busy_q <= 1'b1;
        else if (byte_done)          busy_q <= 1'b0;
    end

    // Done and collision flags with the status-then-data clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            wcol_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (byte_done)      done_q <= 1'b1;
            else if (clear_now) done_q <= 1'b0;
            if (collide)        wcol_q <= 1'b1;
            else if (clear_now) wcol_q <= 1'b0;
            if (clear_now)      armed_q <= 1'b0;
            else if (rd_en && addr == A_STAT && (done_q || wcol_q)) armed_q <= 1'b1;
        end
    end

    // Receive buffer updated once per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         rxbuf_q <= '0;
        else if (byte_done) rxbuf_q <= rx_word;
    end

    // Register read multiplexer.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {1'b0, ctrl_q};
            A_STAT:  rdata = {done_q, wcol_q, 5'b0, dbl_q};
            A_DATA:  rdata = rxbuf_q;
            default: rdata = 8'h00;
        endcase
    end

    assign irq      = ctrl_q.irq_en && done_q;
    assign sck_out  = ctrl_q.cpol ^ (is_master && odd_phase);
    assign mosi_out = is_master && ser_out;
    assign ss_n_out = !(is_master && busy_q);
    assign miso_out = ser_out;
    assign miso_oe  = !is_master && !ss_s;
endmodule

// File: rtl/spi_port_chk.sv
// Temporal checks on the serial port, attached to every instance by bind.
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       is_master,
    input logic       cpol_sel,
    input logic       done_q,
    input logic       wcol_q,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       sck_out,
    input logic       ss_n_out,
    input logic       ss_n_in,
    input logic       miso_oe
);
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && ss_n_out) |-> (sck_out == cpol_sel));

    // R6
    done_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_q) && is_master) |-> $rose(ss_n_out));

    // R7
    wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol_q) |-> $past(wr_en && addr == 2'd2));

    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past((wr_en || rd_en) && addr == 2'd2));

    // R9
    target_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && $past(ss_n_in) && $past(ss_n_in, 2)) |-> !miso_oe);
endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .cpol_sel(cpol_sel),
    .done_q(done_q), .wcol_q(wcol_q), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .sck_out(sck_out), .ss_n_out(ss_n_out),
    .ss_n_in(ss_n_in), .miso_oe(miso_oe)
);

// File: tb/tb_spi_port.sv
// Self-checking bench: a behavioural per-clock model of the controller
// timing plus a bench-side controller that drives the block in target role.
module tb_spi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, sck_out, mosi_out, ss_n_out, miso_out, miso_oe;
    logic       miso_in = 1'b0, sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sck_out(sck_out),
        .mosi_out(mosi_out), .ss_n_out(ss_n_out), .miso_in(miso_in),
        .sck_in(sck_in), .mosi_in(mosi_in), .ss_n_in(ss_n_in),
        .miso_out(miso_out), .miso_oe(miso_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int bit_at(input bit lsb, input int b);
        return lsb ? b : 7 - b;
    endfunction

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Controller transfer compared against the model on every clock.
    task automatic run_master(input logic [6:0] ctrl, input bit dbl,
                              input logic [7:0] txb, input logic [7:0] pat, input int cj);
        bit cpol, cpha, lsb;
        int h, rate;
        cpol = ctrl[3]; cpha = ctrl[2]; lsb = ctrl[4]; rate = int'(ctrl[1:0]);
        case (rate)
            0: h = 2; 1: h = 8; 2: h = 32; default: h = 64;
        endcase
        if (dbl) h = h / 2;
        cpu_wr(2'd0, {1'b0, ctrl});
        cpu_wr(2'd1, {7'b0, dbl});
        miso_in = pat[bit_at(lsb, 0)];
        cpu_wr(2'd2, txb);
        for (int j = 0; j <= 16*h + 1; j++) begin
            int k, b;
            k = j / h;
            if (k > 16) k = 16;
            b = cpha ? ((k == 0) ? 0 : (k - 1) / 2) : k / 2;
            chk("R2 select", ss_n_out, (k >= 16));
            chk("R1/R4 sck", sck_out, cpol ^ k[0]);
            if (k < 16) begin
                chk("R3/R4/R7 mosi", mosi_out, txb[bit_at(lsb, b)]);
                miso_in = pat[bit_at(lsb, b)];
            end
            if (j == cj) begin addr = 2'd2; wdata = ~txb; wr_en = 1'b1; end
            if (j == cj + 1) wr_en = 1'b0;
            @(negedge clk);
        end
    endtask

    // Bench acts as controller; the block is in target role.
    task automatic target_byte(input bit cpol, input bit cpha, input bit lsb,
                               input logic [7:0] txb, input logic [7:0] mob, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            int p;
            p = bit_at(lsb, i);
            if (!cpha) mosi_in = mob[p];
            else       sck_in = ~sck_in;
            if (cpha)  mosi_in = mob[p];
            repeat (8) @(negedge clk);
            chk("R9 target miso", miso_out, txb[p]);
            chk("R9 target oe", miso_oe, 1'b1);
            sck_in = ~sck_in;
            repeat (8) @(negedge clk);
            if (!cpha) sck_in = ~sck_in;
            if (!cpha) repeat (8) @(negedge clk);
        end
    endtask

    task automatic run_target(input logic [6:0] ctrl, input logic [7:0] txb,
                              input logic [7:0] mob, input bit abort);
        logic [7:0] d;
        sck_in = ctrl[3];
        cpu_wr(2'd0, {1'b0, ctrl});
        cpu_wr(2'd2, txb);
        repeat (4) @(negedge clk);
        chk("R9 oe while deselected", miso_oe, 1'b0);
        if (abort) begin
            ss_n_in = 1'b0;
            repeat (4) @(negedge clk);
            target_byte(ctrl[3], ctrl[2], ctrl[4], txb, ~mob, 2);
            ss_n_in = 1'b1;
            repeat (4) @(negedge clk);
            chk("R9 oe after deselect", miso_oe, 1'b0);
            for (int t = 0; t < 4; t++) begin
                sck_in = ~sck_in;
                repeat (6) @(negedge clk);
            end
            cpu_rd(2'd1, d);
            chk("R10 no done on aborted byte", d[7], 1'b0);
        end
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        target_byte(ctrl[3], ctrl[2], ctrl[4], txb, mob, 8);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
        cpu_rd(2'd1, d);
        chk("R6 target done", d[7], 1'b1);
        cpu_rd(2'd2, d);
        chk(abort ? "R10 restart from bit 0" : "R5/R9 target rx", d, mob);
        cpu_rd(2'd1, d);
        chk("R8 cleared", d, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        cpu_rd(2'd0, d); chk("R11 ctrl", d, 8'h00);
        cpu_rd(2'd1, d); chk("R11 stat", d, 8'h00);
        cpu_rd(2'd2, d); chk("R11 data", d, 8'h00);
        chk("R11 ss", ss_n_out, 1'b1);
        chk("R11 sck", sck_out, 1'b0);
        chk("R11 irq", irq, 1'b0);
        chk("R11 oe", miso_oe, 1'b0);

        // Mode 0, divide by 4, msb first, interrupt on.
        run_master(7'b1100000, 1'b0, 8'hA5, 8'h3C, -10);
        chk("R6 irq", irq, 1'b1);
        cpu_rd(2'd1, d); chk("R6 done", d, 8'h80);
        cpu_rd(2'd2, d); chk("R5 rx mode0", d, 8'h3C);
        cpu_rd(2'd1, d); chk("R8 clear", d, 8'h00);
        chk("R6 irq low", irq, 1'b0);

        // Mode 3, divide by 8, lsb first, collision mid-byte.
        run_master(7'b0111101, 1'b1, 8'h96, 8'h5B, 10);
        chk("R6 irq disabled", irq, 1'b0);
        cpu_rd(2'd2, d); chk("R5 rx mode3", d, 8'h5B);
        cpu_rd(2'd1, d); chk("R7 wcol", d, 8'hC1);
        cpu_rd(2'd2, d); chk("R7 rx kept", d, 8'h5B);
        cpu_rd(2'd1, d); chk("R8 clear after seq", d, 8'h01);

        // Mode 1, divide by 64, msb first.
        run_master(7'b0100110, 1'b0, 8'h0F, 8'hF0, -10);
        cpu_rd(2'd1, d); chk("R6 done", d, 8'h80);
        cpu_rd(2'd2, d); chk("R5 rx mode1", d, 8'hF0);

        // Mode 2, divide by 128, lsb first.
        run_master(7'b0111011, 1'b0, 8'hC3, 8'h81, -10);
        cpu_rd(2'd1, d); chk("R6 done", d, 8'h80);
        cpu_rd(2'd2, d); chk("R3 rx lsb", d, 8'h81);

        // Mode 0, double speed, divide by 2.
        run_master(7'b0100000, 1'b1, 8'h7E, 8'hE7, -10);
        cpu_rd(2'd1, d); chk("R1 fastest done", d, 8'h81);
        cpu_rd(2'd2, d); chk("R5 rx fastest", d, 8'hE7);
        cpu_wr(2'd1, 8'h00);

        // Target role, mode 0 msb first, then mode 3 lsb first with abort.
        run_target(7'b0000000, 8'h6A, 8'hB2, 1'b0);
        run_target(7'b0011100, 8'h35, 8'hC9, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule